// File: doc/BRIEF.md
# Linked Breakpoint Address Matcher

This block holds a small bank of breakpoint pairs. Each pair is a 32-bit value register and a control register. Software reaches them over a simple register bus. On every valid instruction fetch, all pairs are compared at once against four inputs: the halfword-aligned fetch address, the current context identifier, the security world and the fetch endianness. A pair that fires sets its bit in a hit vector and raises a debug event. Both outputs are registered and describe the fetch presented one cycle earlier.

Each pair runs in one of four modes:

- **Address match.** The pair fires when the fetch address equals the programmed word address and the fetch touches a selected byte lane.
- **Address mismatch.** The pair fires on any fetch outside the selected lanes of the programmed word.
- **Context-ID match.** The pair fires when the value register equals the current context. Only pairs built with this capability can use the mode.
- **Reserved.** The pair never fires.

On top of the mode, each pair has a security-world filter and a per-pair enable. A pair can also be linked to another pair, so that an address test only fires while a given context is running. In that case the address pair's world filter governs.

Top module: `bkpt_matcher`

## Requirements
- R1: After reset, every value and control register reads zero, and `dbg_event` and `dbg_hit` are low.
- R2: The bus address is {pair index, select}: select 0 is the 32-bit value register and select 1 is the control register. A write takes effect from the next cycle and reads are combinational. The control fields are:
  - mode at bits [22:21]
  - link enable at bit [20]
  - partner number at bits [19:16]
  - world filter at bits [15:14]
  - byte-lane mask at bits [8:5]
  - pair enable at bit [0]

  Every other control bit reads zero and ignores writes, so writing all ones reads back 0x007FC1E1.
- R3: Pairs whose bit in `CTX_CAPABLE` is clear (default: only pairs 2 and 3 are capable) read control bit 21 as zero and ignore writes to it. Such a pair written with mode 01 therefore behaves as an address-match pair (0x005FC1E1 after an all-ones write).
- R4: Mode 00 (address match): the pair fires when value[31:2] equals fetch address [31:2] and the fetch touches a selected lane. `dbg_hit[i]` and `dbg_event` rise in the cycle after the fetch is presented with `fetch_valid` high.
- R5: Byte-lane mask bit n selects byte n of the word in little-endian numbering. The lanes each fetch touches are:

  | Fetch | Lanes touched |
  |---|---|
  | Word | 1111 |
  | Little-endian halfword at address bit 1 = 0 | 0011 |
  | Little-endian halfword at address bit 1 = 1 | 1100 |
  | Big-endian halfword at address bit 1 = 1 | 0011 |
  | Big-endian halfword at address bit 1 = 0 | 1100 |

  A mask of 0000 never matches.
- R6: Mode 10 (address mismatch): the pair fires when its mask is nonzero and the R4 address-and-lane test fails.
- R7: Mode 01 (context match, unlinked): the pair fires when the 32-bit value equals `fetch_ctx` and its mask is 1111. With any other mask it never fires.
- R8: World filter 00 passes both worlds, 01 passes only non-secure (`fetch_secure`=0), 10 passes only secure, and 11 never passes. A pair fires only when its governing filter passes.
- R9: A pair whose enable bit is 0 never fires, and mode 11 never fires.
- R10: When an address pair (mode 00 or 10) has link enable set with partner p, it fires only when all of the following hold in the same fetch:
  - its own address test passes;
  - its own world filter passes;
  - pair p is enabled;
  - pair p is in mode 01;
  - pair p's value equals `fetch_ctx`.

  Pair p's world filter and mask are not used in this test.
- R11: A pair never fires in any of these cases:
  - it is linked to its own number;
  - it is linked to a number of `NPAIR` or more;
  - it is a context pair with link enable set.
- R12: A cycle with `fetch_valid` low produces no hit and no event in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | $clog2(NPAIR)+1 | {pair index, select}; select 1 = control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 31 | Fetch virtual address bits [31:1] |
| fetch_ctx | input | 32 | Current context identifier |
| fetch_secure | input | 1 | 1 = secure world |
| fetch_big_endian | input | 1 | 1 = big-endian fetch |
| fetch_half | input | 1 | 1 = halfword fetch, 0 = word fetch |
| dbg_event | output | 1 | Debug event for the previous cycle's fetch |
| dbg_hit | output | NPAIR | Per-pair fire flags for the previous cycle's fetch |

## Verification
The address test of one pair and the context test of its linked partner are evaluated on the same fetch. They must agree in that single cycle for the linked pair to fire, while the partner's own unlinked firing is judged separately by its own world filter. The bench provokes this directly by giving the two pairs opposite world filters and fetching with a matching context in the secure world: only the address pair is expected to fire. It then breaks each condition in turn (context value, partner enable). Random programming of links, modes and filters over a small pool of addresses and contexts makes such coincidences frequent. Every hit bit is compared against a bench model of the rules above.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int unsigned DATA_W = 32;

    // Control bits that hold state; all others are reserved.
    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h007F_C1E1;

    typedef enum logic [1:0] {
        MODE_ADDR = 2'b00,
        MODE_CTX  = 2'b01,
        MODE_MISS = 2'b10,
        MODE_RSVD = 2'b11
    } bp_mode_e;

    typedef struct packed {
        logic     en;
        bp_mode_e mode;
        logic     link;
        logic [3:0] lnk;
        logic [1:0] world;
        logic [3:0] bas;
    } bp_ctrl_t;

    typedef struct packed {
        logic     en;
        bp_mode_e mode;
        logic     link;
        logic [3:0] lnk;
        logic     addr_ok;
        logic     ctx_ok;
        logic     world_ok;
        logic     bas_full;
    } bp_local_t;

    function automatic bp_ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w, input logic ctx_cap);
        bp_ctrl_t c;
        c.en    = w[0];
        c.mode  = bp_mode_e'({w[22], w[21] & ctx_cap});
        c.link  = w[20];
        c.lnk   = w[19:16];
        c.world = w[15:14];
        c.bas   = w[8:5];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input bp_ctrl_t c);
        return {9'b0, c.mode, c.link, c.lnk, c.world, 5'b0, c.bas, 4'b0, c.en};
    endfunction

endpackage

// File: rtl/bkpt_regbank.sv
module bkpt_regbank
    import bkpt_pkg::*;
#(
    parameter int unsigned      NPAIR       = 4,
    parameter logic [NPAIR-1:0] CTX_CAPABLE = {NPAIR{1'b1}}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wen,
    input  logic [$clog2(NPAIR):0]     bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NPAIR-1:0][DATA_W-1:0] val_o,
    output bp_ctrl_t [NPAIR-1:0]       ctl_o
);

    localparam int unsigned IDX_W = $clog2(NPAIR);

    typedef struct packed {
        logic [NPAIR-1:0][DATA_W-1:0] val;
        bp_ctrl_t [NPAIR-1:0]         ctl;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [IDX_W-1:0] idx;
    logic             sel;
    logic             in_range;

    assign idx      = bus_addr[IDX_W:1];
    assign sel      = bus_addr[0];
    assign in_range = int'(idx) < int'(NPAIR);

    always_comb begin
        bank_d = bank_q;
        if (bus_wen && in_range) begin
            if (sel) begin
                bank_d.ctl[idx] = unpack_ctrl(bus_wdata, CTX_CAPABLE[idx]);
            end else begin
                bank_d.val[idx] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            bus_rdata = sel ? pack_ctrl(bank_q.ctl[idx]) : bank_q.val[idx];
        end
    end

    assign val_o = bank_q.val;
    assign ctl_o = bank_q.ctl;

endmodule

// File: rtl/bkpt_pair_cmp.sv
module bkpt_pair_cmp
    import bkpt_pkg::*;
(
    input  logic [DATA_W-1:0] value_i,
    input  bp_ctrl_t          ctrl_i,
    input  logic [31:1]       fetch_addr,
    input  logic [DATA_W-1:0] fetch_ctx,
    input  logic              fetch_secure,
    input  logic              fetch_big_endian,
    input  logic              fetch_half,
    output bp_local_t         local_o
);

    logic [3:0] lanes;
    logic       word_eq;
    logic       lane_hit;

    always_comb begin
        if (!fetch_half) begin
            lanes = 4'b1111;
        end else if (fetch_addr[1] ^ fetch_big_endian) begin
            lanes = 4'b1100;
        end else begin
            lanes = 4'b0011;
        end
        word_eq  = (value_i[31:2] == fetch_addr[31:2]);
        lane_hit = |(ctrl_i.bas & lanes);

        local_o.en       = ctrl_i.en;
        local_o.mode     = ctrl_i.mode;
        local_o.link     = ctrl_i.link;
        local_o.lnk      = ctrl_i.lnk;
        local_o.ctx_ok   = (value_i == fetch_ctx);
        local_o.bas_full = (ctrl_i.bas == 4'b1111);

        unique case (ctrl_i.mode)
            MODE_ADDR: local_o.addr_ok = word_eq && lane_hit;
            MODE_MISS: local_o.addr_ok = (ctrl_i.bas != 4'b0000) && !(word_eq && lane_hit);
            default:   local_o.addr_ok = 1'b0;
        endcase

        unique case (ctrl_i.world)
            2'b00:   local_o.world_ok = 1'b1;
            2'b01:   local_o.world_ok = !fetch_secure;
            2'b10:   local_o.world_ok = fetch_secure;
            default: local_o.world_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/bkpt_link_resolve.sv
module bkpt_link_resolve
    import bkpt_pkg::*;
#(
    parameter int unsigned NPAIR = 4
) (
    input  bp_local_t [NPAIR-1:0] loc_i,
    output logic [NPAIR-1:0]      fire_o
);

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        logic partner_ok;
        logic is_addr;

        always_comb begin
            partner_ok = 1'b0;
            for (int j = 0; j < int'(NPAIR); j++) begin
                if (loc_i[i].lnk == 4'(j) && j != i) begin
                    partner_ok = loc_i[j].en && (loc_i[j].mode == MODE_CTX) && loc_i[j].ctx_ok;
                end
            end

            is_addr = (loc_i[i].mode == MODE_ADDR) || (loc_i[i].mode == MODE_MISS);

            if (!loc_i[i].en) begin
                fire_o[i] = 1'b0;
            end else if (loc_i[i].mode == MODE_CTX) begin
                fire_o[i] = !loc_i[i].link && loc_i[i].ctx_ok && loc_i[i].bas_full
                            && loc_i[i].world_ok;
            end else if (is_addr) begin
                fire_o[i] = loc_i[i].addr_ok && loc_i[i].world_ok
                            && (!loc_i[i].link || partner_ok);
            end else begin
                fire_o[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/bkpt_matcher.sv
module bkpt_matcher
    import bkpt_pkg::*;
#(
    parameter int unsigned      NPAIR       = 4,
    parameter logic [NPAIR-1:0] CTX_CAPABLE = 4'b1100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wen,
    input  logic [$clog2(NPAIR):0] bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   fetch_valid,
    input  logic [31:1]            fetch_addr,
    input  logic [DATA_W-1:0]      fetch_ctx,
    input  logic                   fetch_secure,
    input  logic                   fetch_big_endian,
    input  logic                   fetch_half,
    output logic                   dbg_event,
    output logic [NPAIR-1:0]       dbg_hit
);

    logic [NPAIR-1:0][DATA_W-1:0] val_w;
    bp_ctrl_t [NPAIR-1:0]         ctrl_w;
    bp_local_t [NPAIR-1:0]        loc_w;
    logic [NPAIR-1:0]             fire_w;

    typedef struct packed {
        logic             ev;
        logic [NPAIR-1:0] hit;
    } out_t;

    out_t out_d, out_q;

    bkpt_regbank #(
        .NPAIR       (NPAIR),
        .CTX_CAPABLE (CTX_CAPABLE)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .val_o     (val_w),
        .ctl_o     (ctrl_w)
    );

    for (genvar g = 0; g < NPAIR; g++) begin : g_cmp
        bkpt_pair_cmp u_cmp (
            .value_i          (val_w[g]),
            .ctrl_i           (ctrl_w[g]),
            .fetch_addr       (fetch_addr),
            .fetch_ctx        (fetch_ctx),
            .fetch_secure     (fetch_secure),
            .fetch_big_endian (fetch_big_endian),
            .fetch_half       (fetch_half),
            .local_o          (loc_w[g])
        );
    end

    bkpt_link_resolve #(
        .NPAIR (NPAIR)
    ) u_link (
        .loc_i  (loc_w),
        .fire_o (fire_w)
    );

    always_comb begin
        out_d.hit = fetch_valid ? fire_w : '0;
        out_d.ev  = fetch_valid && (|fire_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dbg_event = out_q.ev;
    assign dbg_hit   = out_q.hit;

endmodule

// File: rtl/bkpt_matcher_chk.sv
module bkpt_matcher_chk
    import bkpt_pkg::*;
#(
    parameter int unsigned      NPAIR       = 4,
    parameter logic [NPAIR-1:0] CTX_CAPABLE = 4'b1100
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch_valid,
    input logic                 rd_sel,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic                 dbg_event,
    input logic [NPAIR-1:0]     dbg_hit,
    input bp_ctrl_t [NPAIR-1:0] ctrl_q
);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (dbg_hit == '0) && !dbg_event);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |-> ((bus_rdata & ~CTRL_WMASK) == '0));

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[i].en |=> !dbg_hit[i]);

        p_self_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_q[i].link && ctrl_q[i].lnk == 4'(i)) |=> !dbg_hit[i]);

        if (!CTX_CAPABLE[i]) begin : g_nocap
            p_ctx_raz_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_q[i].mode != MODE_CTX && ctrl_q[i].mode != MODE_RSVD);
        end
    end

endmodule

bind bkpt_matcher bkpt_matcher_chk #(
    .NPAIR       (NPAIR),
    .CTX_CAPABLE (CTX_CAPABLE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .rd_sel      (bus_addr[0]),
    .bus_rdata   (bus_rdata),
    .dbg_event   (dbg_event),
    .dbg_hit     (dbg_hit),
    .ctrl_q      (ctrl_w)
);

// File: tb/tb_bkpt_matcher.sv
`timescale 1ns/1ps
module tb_bkpt_matcher;

    localparam int NP = 4;
    localparam logic [NP-1:0] CAP = 4'b1100;
    localparam logic [31:0] WMASK = 32'h007F_C1E1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:1] fetch_addr = '0;
    logic [31:0] fetch_ctx = '0;
    logic        fetch_secure = 1'b0;
    logic        fetch_big_endian = 1'b0;
    logic        fetch_half = 1'b0;
    logic        dbg_event;
    logic [NP-1:0] dbg_hit;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] sh_val [NP];
    logic [31:0] sh_ctl [NP];

    always #2.5 clk = ~clk;

    bkpt_matcher #(.NPAIR(NP), .CTX_CAPABLE(CAP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .fetch_ctx(fetch_ctx), .fetch_secure(fetch_secure),
        .fetch_big_endian(fetch_big_endian), .fetch_half(fetch_half),
        .dbg_event(dbg_event), .dbg_hit(dbg_hit)
    );

    function automatic logic [31:0] mk(input logic en, input logic [1:0] mode, input logic link,
                                       input logic [3:0] lnk, input logic [1:0] world,
                                       input logic [3:0] bas);
        return {9'b0, mode, link, lnk, world, 5'b0, bas, 4'b0, en};
    endfunction

    function automatic logic w_ok(input logic [1:0] w, input logic s);
        return (w == 2'b00) || (w == 2'b01 && !s) || (w == 2'b10 && s);
    endfunction

    function automatic logic [NP-1:0] exp_hits(input logic [31:0] a, input logic [31:0] c,
                                               input logic s, input logic b, input logic h);
        logic [NP-1:0] r = '0;
        logic [3:0] lanes = !h ? 4'b1111 : ((a[1] ^ b) ? 4'b1100 : 4'b0011);
        for (int i = 0; i < NP; i++) begin
            logic [31:0] ct = sh_ctl[i];
            logic [1:0] md = ct[22:21];
            logic [3:0] bs = ct[8:5];
            logic [3:0] lk = ct[19:16];
            logic aeq = (sh_val[i][31:2] == a[31:2]) && ((bs & lanes) != 0);
            logic at = (md == 2'b00) ? aeq : (md == 2'b10) ? (bs != 0 && !aeq) : 1'b0;
            logic wk = w_ok(ct[15:14], s);
            if (!ct[0] || md == 2'b11) r[i] = 1'b0;
            else if (md == 2'b01) r[i] = !ct[20] && sh_val[i] == c && bs == 4'hF && wk;
            else if (!ct[20]) r[i] = at && wk;
            else if (int'(lk) == i || int'(lk) >= NP) r[i] = 1'b0;
            else r[i] = at && wk && sh_ctl[lk][0] && sh_ctl[lk][22:21] == 2'b01 && sh_val[lk] == c;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic sel, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1;
        bus_addr = {idx[1:0], sel};
        bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
        if (sel) sh_ctl[idx] = d & WMASK & (CAP[idx] ? 32'hFFFF_FFFF : ~32'h0020_0000);
        else sh_val[idx] = d;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic sel, input logic [31:0] exp);
        bus_addr = {idx[1:0], sel};
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic fetch(input logic v, input logic [31:0] a, input logic [31:0] c,
                         input logic s, input logic b, input logic h,
                         output logic [NP-1:0] hit, output logic ev);
        @(negedge clk);
        fetch_valid = v;
        fetch_addr = a[31:1];
        fetch_ctx = c;
        fetch_secure = s;
        fetch_big_endian = b;
        fetch_half = h;
        @(negedge clk);
        fetch_valid = 1'b0;
        hit = dbg_hit;
        ev = dbg_event;
    endtask

    task automatic fx(input string tag, input logic [31:0] a, input logic [31:0] c,
                      input logic s, input logic b, input logic h, input logic [NP-1:0] exp);
        logic [NP-1:0] hit;
        logic ev;
        fetch(1'b1, a, c, s, b, h, hit, ev);
        chk({tag, " hit"}, 32'(hit), 32'(exp));
        chk({tag, " event"}, 32'(ev), 32'(|exp));
    endtask

    task automatic clear_all();
        for (int i = 0; i < NP; i++) begin
            wr(i, 1'b1, 32'h0);
            wr(i, 1'b0, 32'h0);
        end
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [NP-1:0] hit;
        logic ev;
        int unused_seed;
        unused_seed = $urandom(32'd1176);
        for (int i = 0; i < NP; i++) begin
            sh_val[i] = '0;
            sh_ctl[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 event", 32'(dbg_event), 0);
        chk("R1 hit", 32'(dbg_hit), 0);
        for (int i = 0; i < NP; i++) begin
            rd_chk("R1 value", i, 1'b0, 0);
            rd_chk("R1 ctrl", i, 1'b1, 0);
        end

        // R2 / R3 register access and masks
        wr(0, 1'b1, 32'hFFFF_FFFF);
        rd_chk("R3 ctrl no-ctx pair", 0, 1'b1, 32'h005F_C1E1);
        wr(2, 1'b1, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl mask", 2, 1'b1, 32'h007F_C1E1);
        wr(1, 1'b0, 32'hDEAD_BEEF);
        rd_chk("R2 value", 1, 1'b0, 32'hDEAD_BEEF);
        clear_all();

        // R3: mode 01 on a pair without capability acts as address match
        wr(0, 1'b0, 32'h0000_1000);
        wr(0, 1'b1, mk(1, 2'b01, 0, 0, 2'b00, 4'hF));
        fx("R3 forced addr mode", 32'h1000, 0, 0, 0, 0, 4'b0001);

        // R4 address match
        wr(0, 1'b1, mk(1, 2'b00, 0, 0, 2'b00, 4'hF));
        fx("R4 match", 32'h1000, 0, 0, 0, 0, 4'b0001);
        fx("R4 other word", 32'h1004, 0, 0, 0, 0, 4'b0000);

        // R5 byte lanes and endianness
        wr(1, 1'b0, 32'h0000_2000);
        wr(1, 1'b1, mk(1, 2'b00, 0, 0, 2'b00, 4'b0011));
        fx("R5 BE half hi", 32'h2002, 0, 0, 1, 1, 4'b0010);
        fx("R5 LE half hi", 32'h2002, 0, 0, 0, 1, 4'b0000);
        fx("R5 LE half lo", 32'h2000, 0, 0, 0, 1, 4'b0010);
        fx("R5 BE half lo", 32'h2000, 0, 0, 1, 1, 4'b0000);
        wr(1, 1'b1, mk(1, 2'b00, 0, 0, 2'b00, 4'b0000));
        fx("R5 empty mask", 32'h2000, 0, 0, 0, 0, 4'b0000);

        // R6 mismatch
        wr(1, 1'b1, mk(1, 2'b10, 0, 0, 2'b00, 4'hF));
        fx("R6 outside", 32'h3000, 0, 0, 0, 0, 4'b0010);
        fx("R6 inside", 32'h2000, 0, 0, 0, 0, 4'b0000);
        wr(1, 1'b1, 32'h0);

        // R7 context match
        wr(2, 1'b0, 32'hC0DE_0001);
        wr(2, 1'b1, mk(1, 2'b01, 0, 0, 2'b00, 4'hF));
        fx("R7 ctx hit", 32'h5000, 32'hC0DE_0001, 0, 0, 0, 4'b0100);
        fx("R7 ctx miss", 32'h5000, 32'hC0DE_0002, 0, 0, 0, 4'b0000);
        wr(2, 1'b1, mk(1, 2'b01, 0, 0, 2'b00, 4'b0111));
        fx("R7 partial mask", 32'h5000, 32'hC0DE_0001, 0, 0, 0, 4'b0000);
        wr(2, 1'b1, 32'h0);

        // R8 world filter
        wr(0, 1'b1, mk(1, 2'b00, 0, 0, 2'b01, 4'hF));
        fx("R8 ns-only secure", 32'h1000, 0, 1, 0, 0, 4'b0000);
        fx("R8 ns-only nonsec", 32'h1000, 0, 0, 0, 0, 4'b0001);
        wr(0, 1'b1, mk(1, 2'b00, 0, 0, 2'b10, 4'hF));
        fx("R8 s-only nonsec", 32'h1000, 0, 0, 0, 0, 4'b0000);
        wr(0, 1'b1, mk(1, 2'b00, 0, 0, 2'b11, 4'hF));
        fx("R8 reserved world", 32'h1000, 0, 1, 0, 0, 4'b0000);

        // R9 enable and reserved mode
        wr(0, 1'b1, mk(0, 2'b00, 0, 0, 2'b00, 4'hF));
        fx("R9 disabled", 32'h1000, 0, 0, 0, 0, 4'b0000);
        wr(3, 1'b0, 32'h0000_1000);
        wr(3, 1'b1, mk(1, 2'b11, 0, 0, 2'b00, 4'hF));
        fx("R9 reserved mode", 32'h1000, 32'h0000_1000, 0, 0, 0, 4'b0000);
        wr(3, 1'b1, 32'h0);

        // R10 linking: address pair world governs, partner world ignored
        wr(0, 1'b1, mk(1, 2'b00, 1, 4'd2, 2'b10, 4'hF));
        wr(2, 1'b0, 32'hC0DE_0007);
        wr(2, 1'b1, mk(1, 2'b01, 0, 0, 2'b01, 4'hF));
        fx("R10 linked fire", 32'h1000, 32'hC0DE_0007, 1, 0, 0, 4'b0001);
        fx("R10 ctx differs", 32'h1000, 32'hC0DE_0008, 1, 0, 0, 4'b0000);
        fx("R10 own world fails", 32'h1000, 32'hC0DE_0007, 0, 0, 0, 4'b0100);
        wr(2, 1'b1, mk(0, 2'b01, 0, 0, 2'b01, 4'hF));
        fx("R10 partner disabled", 32'h1000, 32'hC0DE_0007, 1, 0, 0, 4'b0000);

        // R11 self link, out of range link, linked context pair
        wr(0, 1'b1, mk(1, 2'b00, 1, 4'd0, 2'b00, 4'hF));
        fx("R11 self link", 32'h1000, 0, 0, 0, 0, 4'b0000);
        wr(0, 1'b1, mk(1, 2'b00, 1, 4'd5, 2'b00, 4'hF));
        fx("R11 link out of range", 32'h1000, 0, 0, 0, 0, 4'b0000);
        wr(0, 1'b1, 32'h0);
        wr(3, 1'b0, 32'hC0DE_0009);
        wr(3, 1'b1, mk(1, 2'b01, 1, 4'd0, 2'b00, 4'hF));
        fx("R11 linked ctx pair", 32'h1000, 32'hC0DE_0009, 0, 0, 0, 4'b0000);

        // R12 no fetch
        wr(3, 1'b1, mk(1, 2'b01, 0, 0, 2'b00, 4'hF));
        fetch(1'b0, 32'h1000, 32'hC0DE_0009, 0, 0, 0, hit, ev);
        chk("R12 idle hit", 32'(hit), 0);
        chk("R12 idle event", 32'(ev), 0);

        // Random phase (R4-R11 via model)
        for (int round = 0; round < 120; round++) begin
            for (int i = 0; i < NP; i++) begin
                logic [31:0] v;
                logic [31:0] ct;
                logic [3:0] bs;
                logic [1:0] wd;
                v = ($urandom % 2 == 0) ? (32'h0000_2000 + (($urandom % 4) << 2) + ($urandom % 4))
                                        : (32'hC0DE_0000 + ($urandom % 4));
                bs = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
                wd = ($urandom % 3 != 0) ? 2'b00 : 2'($urandom);
                ct = mk(($urandom % 5) != 0, 2'($urandom), ($urandom % 3) == 0,
                        4'($urandom % 5), wd, bs);
                ct = ct | ($urandom & ~WMASK);
                wr(i, 1'b0, v);
                wr(i, 1'b1, ct);
            end
            for (int k = 0; k < 16; k++) begin
                logic [31:0] a;
                logic [31:0] c;
                logic s, b, h;
                logic [NP-1:0] exp;
                a = 32'h0000_2000 + (($urandom % 5) << 2) + (($urandom % 2) << 1);
                c = 32'hC0DE_0000 + ($urandom % 4);
                s = 1'($urandom);
                b = 1'($urandom);
                h = 1'($urandom);
                exp = exp_hits(a, c, s, b, h);
                fx("R10 random", a, c, s, b, h, exp);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule